// File: doc/BRIEF.md
# Flash Byte-Program and Sector-Erase Sequencer

This block drives a parallel NOR flash over a plain strobed bus: an address, a write-data byte with an output enable, an active-low write strobe, an active-low read strobe and a read-data byte. A single command starts one of two jobs. A program job writes a burst of bytes to consecutive addresses. An erase job clears the one 16 KB sector that holds the given address. Every bus cycle places address and data one clock ahead of the strobe and keeps them one clock after it. The strobe itself lasts a parameterised number of clocks.

For each byte the sequencer writes the unlock pair and the program code to fixed offsets. It then writes the data byte to its target address and reads that address back until the device reports completion. Data bit 7 matching the written bit 7 means the byte is finished. Data bit 5 set means the device gave up. In that case bit 7 is read once more before the byte counts as failed. A failure stops the burst, returns the device to read mode with the reset code, and reports how many units succeeded. Bytes arrive on a valid/ready input, one per byte, and are only taken when the sequencer is ready for the next one.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset both strobes are high (1), `cmd_ready` is 1, and `done` and `dat_ready` are 0.
- R2: A program job writes four bus cycles per byte, in this order: 0xAA to offset 0x5555, 0x55 to offset 0x2AAA, 0xA0 to offset 0x5555, then the data byte to its target. The first byte goes to `cmd_addr` and each later byte goes to the address after the previous one.
- R3: `fl_we_n` stays low for exactly STROBE_CLKS clocks per write. `fl_addr` and `fl_wdata` keep their value from one clock before the strobe falls until one clock after it rises.
- R4: After a data write the target address is read repeatedly. The byte succeeds on the first read whose bit 7 equals the expected bit 7. A byte that is still busy (bit 7 inverted, bit 5 clear) takes three reads when it completes on the third.
- R5: A read with bit 7 mismatched and bit 5 set causes exactly one more read. If that read matches on bit 7, the byte still succeeds.
- R6: If the extra read also mismatches, the sequencer writes 0xF0 and issues no further writes for the job. It then ends with `done_ok`=0 and `done_count` equal to the number of units that completed before the failure.
- R7: A job ends with a one-clock `done` pulse. A program job that succeeds reports `done_ok`=1 and `done_count`=`cmd_len`. A length of 0 ends with no bus cycle, `done_ok`=1 and count 0.
- R8: When `cmd_erase`=1 the job writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 to the sector base, which is `cmd_addr` with its low SECTOR_W bits cleared. It then polls with expected bit 7 = 1 and counts 1 on success or 0 on failure.
- R9: `dat_ready` is high only while the sequencer waits for a byte. While `dat_valid` is low, no bus cycle starts.
- R10: `cmd_ready` is low for the whole job. A command offered during a job is ignored and does not change the writes made.
- R11: The two strobes are never low together, and `fl_oe` is high whenever `fl_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_erase | input | 1 | 1 = sector erase, 0 = byte program |
| cmd_addr | input | ADDR_W | First target address or address inside the sector |
| cmd_len | input | COUNT_W | Number of bytes to program |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Sequencer waits for a byte |
| dat_byte | input | 8 | Byte to program |
| done | output | 1 | One-clock end-of-job pulse |
| done_ok | output | 1 | Job finished without failure |
| done_count | output | COUNT_W | Units completed |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_oe | output | 1 | Write data drive enable |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_rdata | input | 8 | Flash read data |

## Verification
A behavioural flash model answers the status reads in three styles, and each style separates one polling outcome. In the first, bit 7 completes after two busy reads. In the second, bit 5 rises first and bit 7 completes on the extra read. In the third, bit 5 rises and bit 7 never completes. A burst of bytes with both values of bit 7 exposes address stepping and a wrong expected bit, while a failure on the third byte separates the success count from the length. Erase is tried both passing and failing at an address deep in its sector. Stalled data and commands offered mid-job show that neither starts bus activity early.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        ASEL_CMD    = 2'd0,
        ASEL_ALT    = 2'd1,
        ASEL_TARGET = 2'd2
    } asel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_POLL,
        ST_RECHECK,
        ST_RESET,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        BC_IDLE,
        BC_SETUP,
        BC_STROBE,
        BC_HOLD
    } bus_state_e;

    localparam logic [14:0] OFFS_CMD = 15'h5555;
    localparam logic [14:0] OFFS_ALT = 15'h2AAA;

    localparam logic [7:0] CODE_KEY_A      = 8'hAA;
    localparam logic [7:0] CODE_KEY_B      = 8'h55;
    localparam logic [7:0] CODE_PROGRAM    = 8'hA0;
    localparam logic [7:0] CODE_ERASE_ARM  = 8'h80;
    localparam logic [7:0] CODE_SECTOR_GO  = 8'h30;
    localparam logic [7:0] CODE_READ_MODE  = 8'hF0;

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
    import flash_seq_pkg::*;
(
    input  logic        erase,
    input  logic [2:0]  step,
    output logic [7:0]  code,
    output asel_e       sel,
    output logic        use_data,
    output logic        last
);

    always_comb begin
        code     = CODE_KEY_A;
        sel      = ASEL_CMD;
        use_data = 1'b0;
        last     = 1'b0;
        if (!erase) begin
            case (step)
                3'd0: begin code = CODE_KEY_A;   sel = ASEL_CMD; end
                3'd1: begin code = CODE_KEY_B;   sel = ASEL_ALT; end
                3'd2: begin code = CODE_PROGRAM; sel = ASEL_CMD; end
                default: begin
                    sel      = ASEL_TARGET;
                    use_data = 1'b1;
                    last     = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin code = CODE_KEY_A;     sel = ASEL_CMD; end
                3'd1: begin code = CODE_KEY_B;     sel = ASEL_ALT; end
                3'd2: begin code = CODE_ERASE_ARM; sel = ASEL_CMD; end
                3'd3: begin code = CODE_KEY_A;     sel = ASEL_CMD; end
                3'd4: begin code = CODE_KEY_B;     sel = ASEL_ALT; end
                default: begin
                    code = CODE_SECTOR_GO;
                    sel  = ASEL_TARGET;
                    last = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int STROBE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              ack,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_oe,
    output logic              bus_we_n,
    output logic              bus_re_n,
    input  logic [7:0]        bus_rdata
);

    localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

    typedef struct packed {
        bus_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              is_rd;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic [7:0]        rdata;
    } bc_t;

    bc_t q, d;

    always_comb begin
        d   = q;
        ack = 1'b0;
        case (q.st)
            BC_IDLE: begin
                if (req) begin
                    d.addr  = req_addr;
                    d.wdata = req_data;
                    d.is_rd = req_rd;
                    d.st    = BC_SETUP;
                end
            end
            BC_SETUP: begin
                d.cnt = '0;
                d.st  = BC_STROBE;
            end
            BC_STROBE: begin
                if (q.cnt == CNT_LAST) begin
                    if (q.is_rd) d.rdata = bus_rdata;
                    d.st = BC_HOLD;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                ack  = 1'b1;
                d.st = BC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: BC_IDLE, cnt: '0, is_rd: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign rdata     = q.rdata;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;
    assign bus_oe    = (q.st != BC_IDLE) && !q.is_rd;
    assign bus_we_n  = !((q.st == BC_STROBE) && !q.is_rd);
    assign bus_re_n  = !((q.st == BC_STROBE) && q.is_rd);

    // strobe-width monitor
    logic [CNT_W+1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run_q <= '0;
        else if (!bus_we_n) low_run_q <= low_run_q + 1'b1;
        else               low_run_q <= '0;
    end

    assert_strobe_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> (low_run_q == (CNT_W+2)'(STROBE_CLKS)));

    assert_setup_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |=> ($stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int COUNT_W     = 8,
    parameter int STROBE_CLKS = 3,
    parameter int SECTOR_W    = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_erase,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [COUNT_W-1:0] cmd_len,
    input  logic               dat_valid,
    output logic               dat_ready,
    input  logic [7:0]         dat_byte,
    output logic               done,
    output logic               done_ok,
    output logic [COUNT_W-1:0] done_count,
    output logic [ADDR_W-1:0]  fl_addr,
    output logic [7:0]         fl_wdata,
    output logic               fl_oe,
    output logic               fl_we_n,
    output logic               fl_re_n,
    input  logic [7:0]         fl_rdata
);

    localparam logic [ADDR_W-1:0] ADDR_CMD = ADDR_W'(OFFS_CMD);
    localparam logic [ADDR_W-1:0] ADDR_ALT = ADDR_W'(OFFS_ALT);

    typedef struct packed {
        seq_state_e         st;
        logic               erase;
        logic [2:0]         step;
        logic [ADDR_W-1:0]  addr;
        logic [7:0]         dbyte;
        logic [COUNT_W-1:0] len;
        logic [COUNT_W-1:0] count;
        logic               ok;
    } seq_t;

    seq_t q, d;

    logic              bc_req, bc_rd, bc_ack;
    logic [ADDR_W-1:0] bc_addr;
    logic [7:0]        bc_data, bc_rdata;
    logic [7:0]        tbl_code;
    asel_e             tbl_sel;
    logic              tbl_use_data, tbl_last;
    logic              expect7, hit, unit_good;
    logic [COUNT_W-1:0] next_count;

    flash_cmd_table i_table (
        .erase    (q.erase),
        .step     (q.step),
        .code     (tbl_code),
        .sel      (tbl_sel),
        .use_data (tbl_use_data),
        .last     (tbl_last)
    );

    flash_bus_cycle #(
        .ADDR_W      (ADDR_W),
        .STROBE_CLKS (STROBE_CLKS)
    ) i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bc_req),
        .req_rd    (bc_rd),
        .req_addr  (bc_addr),
        .req_data  (bc_data),
        .ack       (bc_ack),
        .rdata     (bc_rdata),
        .bus_addr  (fl_addr),
        .bus_wdata (fl_wdata),
        .bus_oe    (fl_oe),
        .bus_we_n  (fl_we_n),
        .bus_re_n  (fl_re_n),
        .bus_rdata (fl_rdata)
    );

    assign expect7    = q.erase ? 1'b1 : q.dbyte[7];
    assign hit        = (bc_rdata[7] == expect7);
    assign next_count = q.count + 1'b1;

    always_comb begin
        d         = q;
        bc_req    = 1'b0;
        bc_rd     = 1'b0;
        bc_addr   = q.addr;
        bc_data   = '0;
        unit_good = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.erase = cmd_erase;
                    d.len   = cmd_len;
                    d.count = '0;
                    d.step  = '0;
                    d.ok    = 1'b0;
                    if (cmd_erase) begin
                        d.addr = {cmd_addr[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}};
                        d.st   = ST_ISSUE;
                    end else begin
                        d.addr = cmd_addr;
                        if (cmd_len == '0) begin
                            d.ok = 1'b1;
                            d.st = ST_DONE;
                        end else begin
                            d.st = ST_FETCH;
                        end
                    end
                end
            end
            ST_FETCH: begin
                if (dat_valid) begin
                    d.dbyte = dat_byte;
                    d.step  = '0;
                    d.st    = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                bc_req = 1'b1;
                case (tbl_sel)
                    ASEL_CMD: bc_addr = ADDR_CMD;
                    ASEL_ALT: bc_addr = ADDR_ALT;
                    default:  bc_addr = q.addr;
                endcase
                bc_data = tbl_use_data ? q.dbyte : tbl_code;
                if (bc_ack) begin
                    if (tbl_last) d.st = ST_POLL;
                    else          d.step = q.step + 1'b1;
                end
            end
            ST_POLL: begin
                bc_req = 1'b1;
                bc_rd  = 1'b1;
                if (bc_ack) begin
                    if (hit)              unit_good = 1'b1;
                    else if (bc_rdata[5]) d.st = ST_RECHECK;
                end
            end
            ST_RECHECK: begin
                bc_req = 1'b1;
                bc_rd  = 1'b1;
                if (bc_ack) begin
                    if (hit) unit_good = 1'b1;
                    else     d.st = ST_RESET;
                end
            end
            ST_RESET: begin
                bc_req  = 1'b1;
                bc_data = CODE_READ_MODE;
                if (bc_ack) begin
                    d.ok = 1'b0;
                    d.st = ST_DONE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        if (unit_good) begin
            d.count = next_count;
            if (q.erase || (next_count == q.len)) begin
                d.ok = 1'b1;
                d.st = ST_DONE;
            end else begin
                d.addr = q.addr + 1'b1;
                d.st   = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, erase: 1'b0, step: '0, addr: '0, dbyte: '0,
                   len: '0, count: '0, ok: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cmd_ready  = (q.st == ST_IDLE);
    assign dat_ready  = (q.st == ST_FETCH);
    assign done       = (q.st == ST_DONE);
    assign done_ok    = q.ok;
    assign done_count = q.count;

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n));

    assert_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_oe);

    assert_busy_blocks_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_wait_for_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_ready && !dat_valid) |=> (fl_we_n && fl_re_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> (fl_wdata == CODE_READ_MODE));

    assert_fail_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok && !q.erase) |-> (done_count < q.len));

endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;

    localparam int AW = 17;
    localparam int CW = 8;
    localparam int SC = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          cmd_valid = 1'b0, cmd_erase = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_len = '0;
    logic          cmd_ready, dat_ready, done, done_ok;
    logic          dat_valid = 1'b0;
    logic [7:0]    dat_byte = '0;
    logic [CW-1:0] done_count;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          fl_oe, fl_we_n, fl_re_n;

    flash_prog_seq #(.ADDR_W(AW), .COUNT_W(CW), .STROBE_CLKS(SC), .SECTOR_W(14)) i_flash_prog_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .done(done), .done_ok(done_ok), .done_count(done_count),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_oe(fl_oe),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_rdata(fl_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // flash device model and bus monitor
    logic          clr = 1'b0;
    logic          prev_we = 1'b1, prev_re = 1'b1;
    logic [AW-1:0] log_a [0:63];
    logic [7:0]    log_d [0:63];
    int wcount = 0, rcount = 0, prog_idx = 0, rdn = 0, bmode = 0;
    int fail_at = -1, late_at = -1;
    int we_run = 0, last_run = 0, overlap = 0;
    logic busy = 1'b0, arm_p = 1'b0, arm_e = 1'b0;
    logic [7:0] fin = 8'h00;

    // data source
    logic [7:0] feed_buf [0:15];
    int feed_n = 0, feed_idx = 0;
    bit stall = 1'b0;

    always @(posedge clk) begin
        if (clr) begin
            wcount <= 0; rcount <= 0; prog_idx <= 0; rdn <= 0;
            busy <= 1'b0; arm_p <= 1'b0; arm_e <= 1'b0; feed_idx <= 0;
        end else begin
            if (dat_valid && dat_ready) feed_idx <= feed_idx + 1;
            if (!prev_we && fl_we_n) begin
                if (wcount < 64) begin
                    log_a[wcount] <= fl_addr;
                    log_d[wcount] <= fl_wdata;
                end
                wcount <= wcount + 1;
                if (arm_p || (arm_e && fl_wdata == 8'h30)) begin
                    busy     <= 1'b1;
                    fin      <= arm_p ? fl_wdata : 8'hFF;
                    rdn      <= 0;
                    bmode    <= (prog_idx == fail_at) ? 1 : ((prog_idx == late_at) ? 2 : 0);
                    prog_idx <= prog_idx + 1;
                    arm_p    <= 1'b0;
                    arm_e    <= 1'b0;
                end else if (fl_wdata == 8'hA0 && fl_addr == 17'h05555) begin
                    arm_p <= 1'b1;
                end else if (fl_wdata == 8'h80 && fl_addr == 17'h05555) begin
                    arm_e <= 1'b1;
                end else if (fl_wdata == 8'hF0) begin
                    busy <= 1'b0;
                end
            end
            if (!prev_re && fl_re_n) begin
                rcount <= rcount + 1;
                rdn    <= rdn + 1;
            end
        end
        prev_we <= fl_we_n;
        prev_re <= fl_re_n;
        if (!fl_we_n) we_run <= we_run + 1;
        else begin
            if (!prev_we) last_run <= we_run;
            we_run <= 0;
        end
        if (!fl_we_n && (!fl_re_n || !fl_oe)) overlap <= overlap + 1;
    end

    always_comb begin
        if (!busy) fl_rdata = fin;
        else if (bmode == 1) fl_rdata = {~fin[7], 1'b0, 1'b1, 5'b0};
        else if (bmode == 2)
            fl_rdata = (rdn == 0) ? {~fin[7], 7'b0} :
                       (rdn == 1) ? {~fin[7], 1'b0, 1'b1, 5'b0} : fin;
        else fl_rdata = (rdn < 2) ? {~fin[7], 7'b0} : fin;
    end

    always @(negedge clk) begin
        dat_valid <= !stall && (feed_idx < feed_n);
        dat_byte  <= feed_buf[feed_idx % 16];
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_w(input int i, input logic [AW-1:0] a, input logic [7:0] dv, input string req);
        chk(log_a[i] == a && log_d[i] == dv, req, int'({log_a[i], log_d[i]}), int'({a, dv}));
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr = 1'b1; fail_at = -1; late_at = -1; feed_n = 0; stall = 1'b0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic start_cmd(input bit er, input logic [AW-1:0] a, input logic [CW-1:0] n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = er; cmd_addr = a; cmd_len = n;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output bit ok, output int cnt);
        ok = 1'b0; cnt = -1;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                ok = done_ok; cnt = int'(done_count);
                @(negedge clk);
                chk(!done, "R7 done pulse width", int'(done), 0);
                return;
            end
            @(negedge clk);
        end
        chk(1'b0, "R7 done never seen", 0, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(fl_we_n && fl_re_n, "R1 strobes idle", int'({fl_we_n, fl_re_n}), 3);
        chk(cmd_ready, "R1 cmd_ready", int'(cmd_ready), 1);
        chk(!done && !dat_ready, "R1 done/dat_ready", int'({done, dat_ready}), 0);
    endtask

    task automatic t_burst();
        bit ok; int cnt;
        logic [7:0] bytes [0:2];
        bytes[0] = 8'h3C; bytes[1] = 8'hC5; bytes[2] = 8'h81;
        clear_all();
        for (int i = 0; i < 3; i++) feed_buf[i] = bytes[i];
        feed_n = 3;
        start_cmd(1'b0, 17'h01230, 8'd3);
        wait_done(ok, cnt);
        chk(ok && cnt == 3, "R7 burst result", cnt, 3);
        chk(wcount == 12, "R2 write count", wcount, 12);
        for (int i = 0; i < 3; i++) begin
            chk_w(4*i,   17'h05555, 8'hAA, "R2 key A");
            chk_w(4*i+1, 17'h02AAA, 8'h55, "R2 key B");
            chk_w(4*i+2, 17'h05555, 8'hA0, "R2 program code");
            chk_w(4*i+3, 17'h01230 + AW'(i), bytes[i], "R2 data write");
        end
        chk(last_run == SC, "R3 strobe width", last_run, SC);
        chk(rcount == 9, "R4 poll reads", rcount, 9);
    endtask

    task automatic t_late();
        bit ok; int cnt;
        clear_all();
        feed_buf[0] = 8'h5A; feed_n = 1; late_at = 0;
        start_cmd(1'b0, 17'h00400, 8'd1);
        wait_done(ok, cnt);
        chk(ok && cnt == 1, "R5 late completion ok", cnt, 1);
        chk(rcount == 3, "R5 recheck read count", rcount, 3);
        chk(wcount == 4, "R5 no reset write", wcount, 4);
    endtask

    task automatic t_fail();
        bit ok; int cnt;
        clear_all();
        feed_buf[0] = 8'h11; feed_buf[1] = 8'h92; feed_buf[2] = 8'h73; feed_buf[3] = 8'h04;
        feed_n = 4; fail_at = 2;
        start_cmd(1'b0, 17'h1FF00, 8'd4);
        wait_done(ok, cnt);
        chk(!ok, "R6 failure flagged", int'(ok), 0);
        chk(cnt == 2, "R6 success count", cnt, 2);
        chk(wcount == 13, "R6 writes stop", wcount, 13);
        chk(log_d[12] == 8'hF0, "R6 read-mode code", int'(log_d[12]), 8'hF0);
        chk(rcount == 8, "R6 reads incl recheck", rcount, 8);
    endtask

    task automatic t_erase(input bit fail);
        bit ok; int cnt;
        clear_all();
        if (fail) fail_at = 0;
        start_cmd(1'b1, 17'h16123, 8'd0);
        wait_done(ok, cnt);
        chk_w(0, 17'h05555, 8'hAA, "R8 erase key A");
        chk_w(1, 17'h02AAA, 8'h55, "R8 erase key B");
        chk_w(2, 17'h05555, 8'h80, "R8 erase arm");
        chk_w(3, 17'h05555, 8'hAA, "R8 erase key A again");
        chk_w(4, 17'h02AAA, 8'h55, "R8 erase key B again");
        chk_w(5, 17'h14000, 8'h30, "R8 sector go at base");
        if (!fail) begin
            chk(ok && cnt == 1, "R8 erase pass", cnt, 1);
            chk(wcount == 6, "R8 erase write count", wcount, 6);
        end else begin
            chk(!ok && cnt == 0, "R8 erase fail count", cnt, 0);
            chk(wcount == 7 && log_d[6] == 8'hF0, "R6 erase fail reset", wcount, 7);
        end
    endtask

    task automatic t_stall();
        bit ok; int cnt;
        clear_all();
        stall = 1'b1;
        feed_buf[0] = 8'hE7; feed_buf[1] = 8'h18; feed_n = 2;
        start_cmd(1'b0, 17'h00010, 8'd2);
        repeat (20) @(negedge clk);
        chk(wcount == 0 && fl_we_n && fl_re_n, "R9 no cycle without data", wcount, 0);
        chk(dat_ready, "R9 dat_ready while waiting", int'(dat_ready), 1);
        stall = 1'b0;
        wait_done(ok, cnt);
        chk(ok && cnt == 2, "R9 completes after release", cnt, 2);
        chk_w(7, 17'h00011, 8'h18, "R9 second byte written");
    endtask

    task automatic t_busy_cmd();
        bit ok; int cnt;
        clear_all();
        feed_buf[0] = 8'h66; feed_n = 1;
        start_cmd(1'b0, 17'h00200, 8'd1);
        cmd_valid = 1'b1; cmd_erase = 1'b1; cmd_addr = 17'h08000; cmd_len = 8'd5;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!cmd_ready, "R10 busy cmd_ready low", int'(cmd_ready), 0);
        end
        cmd_valid = 1'b0;
        wait_done(ok, cnt);
        chk(ok && cnt == 1 && wcount == 4, "R10 ignored command", wcount, 4);
        chk_w(3, 17'h00200, 8'h66, "R10 original job only");
    endtask

    task automatic t_zero();
        bit ok; int cnt;
        clear_all();
        start_cmd(1'b0, 17'h00300, 8'd0);
        wait_done(ok, cnt);
        chk(ok && cnt == 0 && wcount == 0 && rcount == 0, "R7 zero length", wcount + rcount, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst();
        t_late();
        t_fail();
        t_erase(1'b0);
        t_erase(1'b1);
        t_stall();
        t_busy_cmd();
        t_zero();
        chk(overlap == 0, "R11 strobe overlap or undriven write", overlap, 0);
        finish_run();
    end

endmodule